// File: doc/BRIEF.md
# Filtered Reset Sequencer

This block turns an active-low external reset pin and three internal reset sources into one clean, stretched reset for a microcontroller core and its coprocessor. The pin level goes through a two-flop synchronizer and a glitch counter. A low level only takes effect once it has stayed low long enough, and the internal reset then lasts for a minimum number of clocks or for as long as the pin stays low, whichever is longer.

A power-on pulse and a watchdog timeout both assert the internal reset. They also drive the open-drain reset pin low for a fixed number of clocks, so that other devices on the board reset too. A stop-mode recovery event asserts a short internal reset without pulling the pin low. During that reset a flag tells the watchdog, stop-mode and port-mode registers to keep their contents. After each release the block issues a one-cycle start strobe that carries the fetch address. The interface is control only: every port is a plain level or a pulse, with no valid/ready handshake and no back-pressure.

Top module: `rst_seq_top`

## Requirements
- R1: A run of four or fewer consecutive low clock samples on `rst_pin_n` causes no reset and no start strobe.
- R2: The glitch count restarts from zero whenever the synchronized pin reads high, so two short lows separated by one high cycle cause no reset.
- R3: If the pin is driven low ahead of clock edge E0 and stays low for at least five edges, `core_rst` first reads high after edge E0+6: two edges of synchronizer, then the fifth filtered low sample.
- R4: A reset started by the pin lasts max(18, N-4) cycles for a low of N edges. It releases on the third edge after the pin returns high, and never before 18 cycles.
- R5: While `por_pulse` is high, `core_rst` and `pin_pull_en` are 1, and `keep_regs`, `start_strobe` and `boot_addr` are 0. After the first edge P1 with `por_pulse` low, `pin_pull_en` falls after edge P1+63 and `core_rst` falls after edge P1+66.
- R6: `wdt_timeout` sampled high at edge W sets `core_rst` and `pin_pull_en` from edge W. The pull lasts 64 cycles, and `core_rst` falls after edge W+67.
- R7: `smr_event` sampled high at edge S, with no reset active, gives an 18-cycle `core_rst`. `keep_regs` is high for exactly those cycles and `pin_pull_en` stays low. Resets from any other cause never raise `keep_regs`.
- R8: A watchdog timeout during a stop-mode reset turns it into a full reset: `keep_regs` drops after that edge and the pin is pulled. A stop-mode event during a reset that is already active is ignored.
- R9: `start_strobe` is high for exactly one cycle, 7 edges after the edge on which `core_rst` falls. `boot_addr` reads 0x000C during the strobe and 0 at all other times.
- R10: `pin_pull_en` and `keep_regs` are only high while `core_rst` is high, and they are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_pulse | input | 1 | Power-on pulse, active high, asynchronous |
| rst_pin_n | input | 1 | Level on the open-drain reset pin, active low |
| wdt_timeout | input | 1 | Watchdog expiry, one-cycle pulse |
| smr_event | input | 1 | Stop-mode recovery request, one-cycle pulse |
| core_rst | output | 1 | Internal reset shared by core and coprocessor |
| pin_pull_en | output | 1 | Enable for the pin pull-down driver |
| keep_regs | output | 1 | Tells the mode registers to keep their contents |
| start_strobe | output | 1 | One-cycle run-start pulse |
| boot_addr | output | 16 | Fetch address, valid during the strobe |

## Verification
The bench sweeps low pulse lengths across the four/five-sample filter edge and across the 18-cycle stretch edge (lows of 22 and 23 cycles). A filter that is off by one would reset on a 4-cycle glitch or miss a 5-cycle low, and a stretch that does not take the maximum of the two lengths would show the wrong reset length. A low, one high cycle and another low checks that the glitch count restarts; a counter that only saturates would reset there. The bench models the pin as open-drain, so the pull-down feeds back into the filter. A sequencer that released on its own count, ignoring the pin, would end the watchdog and power-on resets three cycles early. Stop-mode resets are checked for the keep flag, for being upgraded by a watchdog timeout and for being ignored while another reset is active.

// File: rtl/rsq_pkg.sv
package rsq_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE = 2'd0,
    CAUSE_PIN  = 2'd1,
    CAUSE_INT  = 2'd2,
    CAUSE_SMR  = 2'd3
  } rst_cause_e;
endpackage

// File: rtl/rsq_pin_filter.sv
module rsq_pin_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_CYCLES = 4
) (
  input  logic clk,
  input  logic por_pulse,
  input  logic pin_n,
  output logic pin_lo,
  output logic pin_hit
);
  localparam int FILT_W = $clog2(FILT_CYCLES + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [FILT_W-1:0]      lo_cnt;

  // synchronizer chain, one flop per stage
  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk or posedge por_pulse) begin
          if (por_pulse) sync_q[g] <= 1'b1;
          else           sync_q[g] <= pin_n;
        end
      end else begin : g_next
        always_ff @(posedge clk or posedge por_pulse) begin
          if (por_pulse) sync_q[g] <= 1'b1;
          else           sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  assign pin_lo = ~sync_q[SYNC_STAGES-1];

  // count consecutive low samples, restart on any high sample
  always_ff @(posedge clk or posedge por_pulse) begin
    if (por_pulse)                          lo_cnt <= '0;
    else if (!pin_lo)                       lo_cnt <= '0;
    else if (lo_cnt != FILT_W'(FILT_CYCLES)) lo_cnt <= lo_cnt + 1'b1;
  end

  assign pin_hit = pin_lo && (lo_cnt == FILT_W'(FILT_CYCLES));
endmodule

// File: rtl/rsq_hold_ctrl.sv
module rsq_hold_ctrl
  import rsq_pkg::*;
#(
  parameter int HOLD_CYCLES = 18,
  parameter int POR_CYCLES  = 64
) (
  input  logic clk,
  input  logic por_pulse,
  input  logic pin_lo,
  input  logic pin_hit,
  input  logic wdt_timeout,
  input  logic smr_event,
  output logic rst_q,
  output logic pull_en,
  output logic keep_flag
);
  localparam int HOLD_W = $clog2(HOLD_CYCLES);
  localparam int PULL_W = $clog2(POR_CYCLES + 1);

  logic [HOLD_W-1:0] hold_cnt;
  logic [PULL_W-1:0] pull_cnt;
  rst_cause_e        cause;

  always_ff @(posedge clk or posedge por_pulse) begin
    if (por_pulse)                 pull_cnt <= PULL_W'(POR_CYCLES);
    else if (wdt_timeout)          pull_cnt <= PULL_W'(POR_CYCLES);
    else if (pull_cnt != '0)       pull_cnt <= pull_cnt - 1'b1;
  end

  always_ff @(posedge clk or posedge por_pulse) begin
    if (por_pulse) begin
      rst_q    <= 1'b1;
      cause    <= CAUSE_INT;
      hold_cnt <= HOLD_W'(HOLD_CYCLES - 1);
    end else if (wdt_timeout) begin
      rst_q    <= 1'b1;
      cause    <= CAUSE_INT;
      hold_cnt <= HOLD_W'(HOLD_CYCLES - 1);
    end else if (pin_hit && (!rst_q || cause == CAUSE_SMR)) begin
      rst_q    <= 1'b1;
      cause    <= CAUSE_PIN;
      hold_cnt <= HOLD_W'(HOLD_CYCLES - 1);
    end else if (smr_event && !rst_q) begin
      rst_q    <= 1'b1;
      cause    <= CAUSE_SMR;
      hold_cnt <= HOLD_W'(HOLD_CYCLES - 1);
    end else if (rst_q) begin
      if (hold_cnt != '0) begin
        hold_cnt <= hold_cnt - 1'b1;
      end else if (pull_cnt == '0 && !pin_lo) begin
        rst_q <= 1'b0;
        cause <= CAUSE_NONE;
      end
    end
  end

  assign pull_en   = (pull_cnt != '0);
  assign keep_flag = rst_q && (cause == CAUSE_SMR);
endmodule

// File: rtl/rsq_start_gen.sv
module rsq_start_gen #(
  parameter int          START_DLY = 7,
  parameter int          ADDR_W    = 16,
  parameter logic [15:0] BOOT_ADDR = 16'h000C
) (
  input  logic              clk,
  input  logic              por_pulse,
  input  logic              rst_q,
  output logic              strobe,
  output logic [ADDR_W-1:0] addr
);
  localparam int DLY_W = $clog2(START_DLY + 1);

  logic [DLY_W-1:0] dly_cnt;

  always_ff @(posedge clk or posedge por_pulse) begin
    if (por_pulse) begin
      dly_cnt <= '0;
      strobe  <= 1'b0;
    end else if (rst_q) begin
      dly_cnt <= DLY_W'(START_DLY);
      strobe  <= 1'b0;
    end else begin
      strobe <= (dly_cnt == DLY_W'(1));
      if (dly_cnt != '0) dly_cnt <= dly_cnt - 1'b1;
    end
  end

  assign addr = strobe ? ADDR_W'(BOOT_ADDR) : '0;
endmodule

// File: rtl/rst_seq_top.sv
module rst_seq_top #(
  parameter int          SYNC_STAGES = 2,
  parameter int          FILT_CYCLES = 4,
  parameter int          HOLD_CYCLES = 18,
  parameter int          POR_CYCLES  = 64,
  parameter int          START_DLY   = 7,
  parameter int          ADDR_W      = 16,
  parameter logic [15:0] BOOT_ADDR   = 16'h000C
) (
  input  logic              clk,
  input  logic              por_pulse,
  input  logic              rst_pin_n,
  input  logic              wdt_timeout,
  input  logic              smr_event,
  output logic              core_rst,
  output logic              pin_pull_en,
  output logic              keep_regs,
  output logic              start_strobe,
  output logic [ADDR_W-1:0] boot_addr
);
  logic pin_lo;
  logic pin_hit;

  rsq_pin_filter #(
    .SYNC_STAGES (SYNC_STAGES),
    .FILT_CYCLES (FILT_CYCLES)
  ) filt_i (
    .clk       (clk),
    .por_pulse (por_pulse),
    .pin_n     (rst_pin_n),
    .pin_lo    (pin_lo),
    .pin_hit   (pin_hit)
  );

  rsq_hold_ctrl #(
    .HOLD_CYCLES (HOLD_CYCLES),
    .POR_CYCLES  (POR_CYCLES)
  ) hold_i (
    .clk         (clk),
    .por_pulse   (por_pulse),
    .pin_lo      (pin_lo),
    .pin_hit     (pin_hit),
    .wdt_timeout (wdt_timeout),
    .smr_event   (smr_event),
    .rst_q       (core_rst),
    .pull_en     (pin_pull_en),
    .keep_flag   (keep_regs)
  );

  rsq_start_gen #(
    .START_DLY (START_DLY),
    .ADDR_W    (ADDR_W),
    .BOOT_ADDR (BOOT_ADDR)
  ) start_i (
    .clk       (clk),
    .por_pulse (por_pulse),
    .rst_q     (core_rst),
    .strobe    (start_strobe),
    .addr      (boot_addr)
  );
endmodule

// File: rtl/rst_seq_chk.sv
module rst_seq_chk #(
  parameter int          HOLD_CYCLES = 18,
  parameter int          ADDR_W      = 16,
  parameter logic [15:0] BOOT_ADDR   = 16'h000C
) (
  input logic              clk,
  input logic              por_pulse,
  input logic              wdt_timeout,
  input logic              core_rst,
  input logic              pin_pull_en,
  input logic              keep_regs,
  input logic              start_strobe,
  input logic [ADDR_W-1:0] boot_addr
);
  logic [15:0] hi_len;

  always_ff @(posedge clk or posedge por_pulse) begin
    if (por_pulse)             hi_len <= '0;
    else if (!core_rst)        hi_len <= '0;
    else if (hi_len != 16'hFFFF) hi_len <= hi_len + 1'b1;
  end

  assert_min_hold_R4: assert property (@(posedge clk) disable iff (por_pulse)
    $fell(core_rst) |-> (hi_len >= 16'(HOLD_CYCLES)));

  assert_wdt_response_R6: assert property (@(posedge clk) disable iff (por_pulse)
    wdt_timeout |=> (core_rst && pin_pull_en && !keep_regs));

  assert_smr_no_pull_R7: assert property (@(posedge clk) disable iff (por_pulse)
    keep_regs |-> !pin_pull_en);

  assert_strobe_outside_reset_R9: assert property (@(posedge clk) disable iff (por_pulse)
    start_strobe |-> !core_rst);

  assert_strobe_single_R9: assert property (@(posedge clk) disable iff (por_pulse)
    start_strobe |=> !start_strobe);

  assert_boot_addr_R9: assert property (@(posedge clk) disable iff (por_pulse)
    start_strobe |-> (boot_addr == ADDR_W'(BOOT_ADDR)));

  assert_pull_in_reset_R10: assert property (@(posedge clk) disable iff (por_pulse)
    pin_pull_en |-> core_rst);

  assert_keep_in_reset_R10: assert property (@(posedge clk) disable iff (por_pulse)
    keep_regs |-> core_rst);
endmodule

bind rst_seq_top rst_seq_chk #(
  .HOLD_CYCLES (HOLD_CYCLES),
  .ADDR_W      (ADDR_W),
  .BOOT_ADDR   (BOOT_ADDR)
) chk_i (
  .clk          (clk),
  .por_pulse    (por_pulse),
  .wdt_timeout  (wdt_timeout),
  .core_rst     (core_rst),
  .pin_pull_en  (pin_pull_en),
  .keep_regs    (keep_regs),
  .start_strobe (start_strobe),
  .boot_addr    (boot_addr)
);

// File: tb/rst_seq_top_tb_top.sv
module rst_seq_top_tb_top;
  logic        clk = 1'b0;
  logic        por_pulse = 1'b1;
  logic        ext_n = 1'b1;
  logic        wdt_timeout = 1'b0;
  logic        smr_event = 1'b0;
  logic        core_rst, pin_pull_en, keep_regs, start_strobe;
  logic [15:0] boot_addr;
  logic        rst_pin_n;

  always #5 clk = ~clk;

  // open-drain pin: external driver wired with the block's own pull-down
  assign rst_pin_n = ext_n & ~pin_pull_en;

  rst_seq_top dut_i (
    .clk          (clk),
    .por_pulse    (por_pulse),
    .rst_pin_n    (rst_pin_n),
    .wdt_timeout  (wdt_timeout),
    .smr_event    (smr_event),
    .core_rst     (core_rst),
    .pin_pull_en  (pin_pull_en),
    .keep_regs    (keep_regs),
    .start_strobe (start_strobe),
    .boot_addr    (boot_addr)
  );

  int vec = 0;
  int miss = 0;
  int cyc = 0;
  int rise_cyc = 0, fall_cyc = 0, pull_fall_cyc = 0, strobe_cyc = 0;
  int rise_cnt = 0, strobe_cnt = 0, keep_cycles = 0, pull_cycles = 0, bad_addr = 0;
  int strobe_addr = 0;
  logic prev_rst = 1'b0, prev_pull = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: samples outputs mid-cycle
  always @(negedge clk) begin
    if (core_rst && !prev_rst) begin rise_cyc = cyc; rise_cnt++; end
    if (!core_rst && prev_rst) fall_cyc = cyc;
    if (prev_pull && !pin_pull_en) pull_fall_cyc = cyc;
    if (keep_regs) keep_cycles++;
    if (pin_pull_en) pull_cycles++;
    if (start_strobe) begin strobe_cyc = cyc; strobe_cnt++; strobe_addr = int'(boot_addr); end
    if (!start_strobe && boot_addr != 16'h0) bad_addr++;
    prev_rst  = core_rst;
    prev_pull = pin_pull_en;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    vec++;
    if (!ok) begin
      miss++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_len(input int n);
    if (n < 5) return 0;
    return (n - 4 > 18) ? n - 4 : 18;
  endfunction

  task automatic pin_pulse(input int n);
    int t0, br, bs, bk;
    @(negedge clk);
    t0 = cyc + 1; br = rise_cnt; bs = strobe_cnt; bk = keep_cycles;
    ext_n = 1'b0;
    repeat (n) @(negedge clk);
    ext_n = 1'b1;
    repeat (40) @(negedge clk);
    if (n < 5) begin
      chk(rise_cnt == br, "R1", "reset count after short low", rise_cnt - br, 0);
      chk(strobe_cnt == bs, "R1", "strobe count after short low", strobe_cnt - bs, 0);
    end else begin
      chk(rise_cnt == br + 1, "R3", "reset count", rise_cnt - br, 1);
      chk(rise_cyc - t0 == 6, "R3", "rise offset", rise_cyc - t0, 6);
      chk(fall_cyc - rise_cyc == exp_len(n), "R4", "reset length",
          fall_cyc - rise_cyc, exp_len(n));
      chk(strobe_cyc - fall_cyc == 7, "R9", "strobe offset", strobe_cyc - fall_cyc, 7);
      chk(strobe_cnt == bs + 1, "R9", "strobe count", strobe_cnt - bs, 1);
      chk(strobe_addr == 12, "R9", "boot address", strobe_addr, 12);
      chk(keep_cycles == bk, "R7", "keep cycles on pin reset", keep_cycles - bk, 0);
    end
  endtask

  initial begin
    int p1, w, s, br, bk, bp, t2, gap;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    #1;
    chk(core_rst == 1'b1, "R5", "core_rst during power-on", core_rst, 1);
    chk(pin_pull_en == 1'b1, "R5", "pull during power-on", pin_pull_en, 1);
    chk(keep_regs == 1'b0 && start_strobe == 1'b0 && boot_addr == 16'h0, "R5",
        "keep/strobe/addr during power-on", int'({keep_regs, start_strobe}), 0);
    @(negedge clk);
    por_pulse = 1'b0;
    p1 = cyc + 1;
    repeat (90) @(negedge clk);
    chk(pull_fall_cyc == p1 + 63, "R5", "pull release", pull_fall_cyc - p1, 63);
    chk(fall_cyc == p1 + 66, "R5", "reset release", fall_cyc - p1, 66);
    chk(strobe_cyc - fall_cyc == 7, "R9", "strobe after power-on", strobe_cyc - fall_cyc, 7);
    chk(bad_addr == 0, "R9", "address outside strobe", bad_addr, 0);

    // filter boundaries and stretch boundaries
    pin_pulse(1); pin_pulse(4); pin_pulse(5);
    pin_pulse(22); pin_pulse(23); pin_pulse(40);

    // glitch restart: 4 low, 1 high, 4 low
    br = rise_cnt;
    @(negedge clk); ext_n = 1'b0;
    repeat (4) @(negedge clk); ext_n = 1'b1;
    @(negedge clk); ext_n = 1'b0;
    repeat (4) @(negedge clk); ext_n = 1'b1;
    repeat (20) @(negedge clk);
    chk(rise_cnt == br, "R2", "reset after split glitch", rise_cnt - br, 0);
    // 4 low, 1 high, then 6 low: rise counts from second low
    @(negedge clk); ext_n = 1'b0;
    repeat (4) @(negedge clk); ext_n = 1'b1;
    @(negedge clk); ext_n = 1'b0; t2 = cyc + 1;
    repeat (6) @(negedge clk); ext_n = 1'b1;
    repeat (40) @(negedge clk);
    chk(rise_cyc - t2 == 6, "R2", "rise counted from second low", rise_cyc - t2, 6);

    // watchdog
    @(negedge clk); w = cyc + 1; wdt_timeout = 1'b1;
    @(negedge clk); wdt_timeout = 1'b0;
    chk(core_rst && pin_pull_en && !keep_regs, "R6", "state after timeout",
        int'({core_rst, pin_pull_en, keep_regs}), 6);
    repeat (90) @(negedge clk);
    chk(rise_cyc == w, "R6", "rise edge", rise_cyc - w, 0);
    chk(pull_fall_cyc - w == 64, "R6", "pull length", pull_fall_cyc - w, 64);
    chk(fall_cyc - w == 67, "R6", "reset length", fall_cyc - w, 67);
    chk(strobe_cyc - fall_cyc == 7, "R9", "strobe after watchdog", strobe_cyc - fall_cyc, 7);

    // stop-mode recovery
    bk = keep_cycles; bp = pull_cycles;
    @(negedge clk); s = cyc + 1; smr_event = 1'b1;
    @(negedge clk); smr_event = 1'b0;
    chk(keep_regs == 1'b1, "R7", "keep flag raised", keep_regs, 1);
    repeat (40) @(negedge clk);
    chk(fall_cyc - s == 18, "R7", "stop-mode reset length", fall_cyc - s, 18);
    chk(keep_cycles - bk == 18, "R7", "keep cycles", keep_cycles - bk, 18);
    chk(pull_cycles == bp, "R7", "no pull on stop-mode", pull_cycles - bp, 0);
    chk(strobe_cyc - fall_cyc == 7, "R9", "strobe after stop-mode", strobe_cyc - fall_cyc, 7);

    // stop-mode during pin reset is ignored
    bk = keep_cycles;
    @(negedge clk); ext_n = 1'b0; t2 = cyc + 1;
    repeat (12) @(negedge clk); smr_event = 1'b1;
    @(negedge clk); smr_event = 1'b0;
    repeat (17) @(negedge clk); ext_n = 1'b1;
    repeat (40) @(negedge clk);
    chk(keep_cycles == bk, "R8", "keep during pin reset", keep_cycles - bk, 0);
    chk(fall_cyc - rise_cyc == 26, "R8", "pin reset length unchanged", fall_cyc - rise_cyc, 26);

    // watchdog upgrades stop-mode reset
    @(negedge clk); smr_event = 1'b1;
    @(negedge clk); smr_event = 1'b0;
    repeat (4) @(negedge clk); w = cyc + 1; wdt_timeout = 1'b1;
    @(negedge clk); wdt_timeout = 1'b0;
    chk(!keep_regs && pin_pull_en, "R8", "keep dropped and pull on",
        int'({keep_regs, pin_pull_en}), 1);
    repeat (90) @(negedge clk);
    chk(fall_cyc - w == 67, "R8", "upgraded reset length", fall_cyc - w, 67);

    // random pulse lengths
    for (int i = 0; i < 30; i++) begin
      gap = $urandom_range(0, 5);
      repeat (gap) @(negedge clk);
      pin_pulse($urandom_range(1, 36));
    end
    chk(bad_addr == 0, "R9", "address outside strobe", bad_addr, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    vec++; miss++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
    $finish;
  end
endmodule